// File: doc/BRIEF.md
# Burst Memory Wait-State Sequencer

This block turns processor bus requests into timed beats for an asynchronous page-mode DRAM array built from two interleaved banks. A request carries an address, a direction, an access size and a flag that asks for a full 16-byte line instead of a single transfer. The sequencer counts wait states for each beat, pulses a per-beat acknowledge back to the processor, walks the beat address through the line, and drives row and column strobe timing to the bank that holds each beat.

Latencies come from a packed configuration vector that a register file outside the block holds. Every region (main DRAM, video DRAM, ROM) has its own four fields: a first-beat and a later-beat count for reads, and the same pair for writes. This lets slow patterns such as 6-3-3-3 be set when the bus clock is raised, while 5-2-2-2 reads and 4-2-2-2 writes are used at the base clock. A simple refresh request/grant pair lets a refresh engine take the array, but only between transfers.

Top module: `line_wait_seq`

## Requirements
- R1: The region is chosen from address bits [31:28]: value 4 selects ROM (region index 2), value 5 selects video DRAM (index 1), and any other value selects main DRAM (index 0). The latency field for region r and slot s is `cfg_lat[(4*r+s)*4 +: 4]`, where slot 0 is the read first beat, slot 1 the read later beats, slot 2 the write first beat and slot 3 the write later beats.
- R2: A read line burst gives exactly four acknowledges. If the request is taken at clock edge 0, they come in cycles F, F+N, F+2N and F+3N, where F and N are the region's read first-beat and later-beat fields.
- R3: A write line burst follows the same pattern as R2, using the region's write fields (slots 2 and 3).
- R4: A single transfer gives exactly one acknowledge, in cycle F of its direction and region, and never uses the later-beat field.
- R5: A latency field that holds 0 acts as 1.
- R6: In a line burst, the beat address keeps bits [31:4] of the request. Bits [3:2] start at the request's value and increase by one per beat, wrapping from 3 to 0. Bits [1:0] read as 0. A single transfer presents the request address unchanged.
- R7: Bank select equals beat address bit 2. While a beat is acknowledged, col_strobe is the one-hot of that bank. During a transfer, row_strobe covers both banks for a line and only the addressed bank for a single transfer. A ROM transfer drives neither strobe.
- R8: The byte enables beat_be[3:0] are 4'b1111 for a line burst and for size 2 or 3. For size 0 (byte) only lane addr[1:0] is set. For size 1 (halfword) they are 4'b0011 when addr[1] is 0 and 4'b1100 when it is 1.
- R9: A refresh is granted only from the idle state. The grant stays high while ref_req stays high, and it is released on the first edge after ref_req drops. Refresh beats a new request presented in the same cycle. No request is taken while refresh is granted. A refresh asked for during a burst is granted two cycles after the last acknowledge.
- R10: The latencies are captured when the request is taken. Changing cfg_lat during a transfer has no effect on that transfer.
- R11: After reset, busy, beat_ack and ref_gnt are low. busy is high from the cycle after a request is taken until the last acknowledge. It is low in the following cycle, and a request is taken only while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Transfer request, taken while idle |
| req_addr | input | ADDR_W | Byte address of the transfer |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_line | input | 1 | Request a four-beat 16-byte line burst |
| cfg_lat | input | CFG_W | Packed latency fields, layout as in R1 |
| ref_req | input | 1 | Refresh request |
| busy | output | 1 | Transfer or refresh in progress |
| beat_ack | output | 1 | One-cycle acknowledge at the end of each beat |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_be | output | 4 | Byte lane enables of the current beat |
| bank_sel | output | 1 | Bank holding the current beat |
| row_strobe | output | 2 | Per-bank row strobe, active high |
| col_strobe | output | 2 | Per-bank column strobe, active high |
| ref_gnt | output | 1 | Refresh grant |

## Verification
On every cycle the assertions check the following. The column strobe is one-hot and appears only with an acknowledge. The line part of the beat address holds steady through a transfer. An acknowledge happens only while busy. A refresh grant starts only from idle, and it silences both strobes and acknowledges. The exact beat spacing for each region, direction and field value, the zero-field clamp, the address wrap order, the byte enables and the immunity to configuration changes in mid-transfer depend on arithmetic over the programmed fields. Only the bench's sweeps, which compare every cycle of each transfer with computed acknowledge times, can show these.

// File: rtl/lws_pkg.sv
package lws_pkg;
  localparam int LINE_BEATS = 4;
  localparam int LANES      = 4;
  localparam int SLOTS      = 4;
  localparam int NUM_REGIONS = 3;

  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_VRAM = 2'd1,
    RGN_ROM  = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RFSH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lws_region_decode.sv
module lws_region_decode
  import lws_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter logic [TAG_W-1:0] ROM_TAG  = 'h4,
  parameter logic [TAG_W-1:0] VRAM_TAG = 'h5
) (
  input  logic [TAG_W-1:0] tag,
  output region_e          region
);
  always_comb begin
    if (tag == ROM_TAG)       region = RGN_ROM;
    else if (tag == VRAM_TAG) region = RGN_VRAM;
    else                      region = RGN_RAM;
  end
endmodule

// File: rtl/lws_lat_select.sv
module lws_lat_select
  import lws_pkg::*;
#(
  parameter int LAT_W = 4,
  parameter int CFG_W = NUM_REGIONS * SLOTS * LAT_W
) (
  input  logic [CFG_W-1:0] cfg,
  input  region_e          region,
  input  logic             is_write,
  output logic [LAT_W-1:0] lat_first,
  output logic [LAT_W-1:0] lat_next
);
  logic [LAT_W-1:0] raw_first;
  logic [LAT_W-1:0] raw_next;
  int               slot_base;

  always_comb begin
    slot_base = int'(region) * SLOTS + (is_write ? 2 : 0);
    raw_first = cfg[slot_base*LAT_W +: LAT_W];
    raw_next  = cfg[(slot_base+1)*LAT_W +: LAT_W];
  end

  // a zero field would never expire: hold it at one clock
  assign lat_first = (raw_first == '0) ? LAT_W'(1) : raw_first;
  assign lat_next  = (raw_next  == '0) ? LAT_W'(1) : raw_next;
endmodule

// File: rtl/lws_byte_lanes.sv
module lws_byte_lanes
  import lws_pkg::*;
#(
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic [LANE_W-1:0] addr_lo,
  input  logic [1:0]        size,
  input  logic              line,
  output logic [LANES-1:0]  be
);
  always_comb begin
    if (line || size[1]) begin
      be = '1;
    end else if (size == 2'd1) begin
      be = addr_lo[1] ? 4'b1100 : 4'b0011;
    end else begin
      be = LANES'(1) << addr_lo;
    end
  end
endmodule

// File: rtl/line_wait_seq.sv
module line_wait_seq
  import lws_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LAT_W  = 4,
  parameter int TAG_W  = 4,
  parameter logic [TAG_W-1:0] ROM_TAG  = 'h4,
  parameter logic [TAG_W-1:0] VRAM_TAG = 'h5,
  parameter int CFG_W  = NUM_REGIONS * SLOTS * LAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_line,
  input  logic [CFG_W-1:0]  cfg_lat,
  input  logic              ref_req,
  output logic              busy,
  output logic              beat_ack,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [LANES-1:0]  beat_be,
  output logic              bank_sel,
  output logic [1:0]        row_strobe,
  output logic [1:0]        col_strobe
  ,output logic             ref_gnt
);
  localparam int LANE_W   = $clog2(LANES);
  localparam int IDX_W    = $clog2(LINE_BEATS);
  localparam int LINE_LSB = LANE_W + IDX_W;
  localparam int NBANK    = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_act_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_act_n = rst_sync_q[1];

  // request-side decode
  region_e          req_region;
  logic [LAT_W-1:0] req_first;
  logic [LAT_W-1:0] req_next;

  lws_region_decode #(
    .TAG_W(TAG_W), .ROM_TAG(ROM_TAG), .VRAM_TAG(VRAM_TAG)
  ) u_rgn (
    .tag    (req_addr[ADDR_W-1 -: TAG_W]),
    .region (req_region)
  );

  lws_lat_select #(.LAT_W(LAT_W), .CFG_W(CFG_W)) u_lat (
    .cfg       (cfg_lat),
    .region    (req_region),
    .is_write  (req_write),
    .lat_first (req_first),
    .lat_next  (req_next)
  );

  // state
  seq_state_e        st_q,     st_d;
  logic [LAT_W-1:0]  cnt_q,    cnt_d;
  logic [LAT_W-1:0]  next_q,   next_d;
  logic [IDX_W-1:0]  left_q,   left_d;
  logic [IDX_W-1:0]  idx_q,    idx_d;
  logic [ADDR_W-1:0] base_q,   base_d;
  logic              line_q,   line_d;
  logic [1:0]        size_q,   size_d;
  region_e           region_q, region_d;
  logic              take_req;
  logic              cap_en;
  logic              beat_end;

  assign take_req = (st_q == ST_IDLE) && !ref_req && req_valid;
  assign beat_end = (st_q == ST_XFER) && (cnt_q == LAT_W'(1));
  assign cap_en   = take_req;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    next_d   = next_q;
    left_d   = left_q;
    idx_d    = idx_q;
    base_d   = base_q;
    line_d   = line_q;
    size_d   = size_q;
    region_d = region_q;
    if (cap_en) begin
      next_d   = req_next;
      base_d   = req_addr;
      line_d   = req_line;
      size_d   = req_size;
      region_d = req_region;
      idx_d    = req_addr[LINE_LSB-1:LANE_W];
      left_d   = req_line ? IDX_W'(LINE_BEATS - 1) : '0;
    end
    unique case (st_q)
      ST_IDLE: begin
        if (ref_req) begin
          st_d = ST_RFSH;
        end else if (req_valid) begin
          st_d  = ST_XFER;
          cnt_d = req_first;
        end
      end
      ST_XFER: begin
        if (beat_end) begin
          if (left_q != '0) begin
            cnt_d  = next_q;
            left_d = left_q - IDX_W'(1);
            idx_d  = idx_q + IDX_W'(1);
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q - LAT_W'(1);
        end
      end
      ST_RFSH: begin
        if (!ref_req) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_act_n) begin
    if (!rst_act_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      next_q   <= '0;
      left_q   <= '0;
      idx_q    <= '0;
      base_q   <= '0;
      line_q   <= 1'b0;
      size_q   <= 2'd0;
      region_q <= RGN_RAM;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      next_q   <= next_d;
      left_q   <= left_d;
      idx_q    <= idx_d;
      base_q   <= base_d;
      line_q   <= line_d;
      size_q   <= size_d;
      region_q <= region_d;
    end
  end

  // outputs
  logic in_xfer;
  logic is_dram;

  assign in_xfer  = (st_q == ST_XFER);
  assign is_dram  = (region_q != RGN_ROM);
  assign busy     = (st_q != ST_IDLE);
  assign ref_gnt  = (st_q == ST_RFSH);
  assign beat_ack = beat_end;

  assign beat_addr = line_q ? {base_q[ADDR_W-1:LINE_LSB], idx_q, {LANE_W{1'b0}}}
                            : base_q;
  assign bank_sel  = beat_addr[LANE_W];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign row_strobe[b] = in_xfer && is_dram && (line_q || (bank_sel == 1'(b)));
    assign col_strobe[b] = beat_end && is_dram && (bank_sel == 1'(b));
  end

  lws_byte_lanes u_be (
    .addr_lo (base_q[LANE_W-1:0]),
    .size    (size_q),
    .line    (line_q),
    .be      (beat_be)
  );
endmodule

// File: rtl/lws_checker.sv
module lws_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_act_n,
  input logic              busy,
  input logic              beat_ack,
  input logic              ref_gnt,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [1:0]        row_strobe,
  input logic [1:0]        col_strobe
);
  a_r7_col_onehot: assert property (@(posedge clk) disable iff (!rst_act_n)
    $onehot0(col_strobe));

  a_r7_col_with_ack: assert property (@(posedge clk) disable iff (!rst_act_n)
    (col_strobe != 2'b00) |-> beat_ack);

  a_r6_line_stable: assert property (@(posedge clk) disable iff (!rst_act_n)
    (busy && !ref_gnt && $past(busy) && !$past(ref_gnt))
      |-> $stable(beat_addr[ADDR_W-1:4]));

  a_r11_ack_busy: assert property (@(posedge clk) disable iff (!rst_act_n)
    beat_ack |-> busy);

  a_r9_gnt_from_idle: assert property (@(posedge clk) disable iff (!rst_act_n)
    $rose(ref_gnt) |-> !$past(busy));

  a_r9_gnt_quiet: assert property (@(posedge clk) disable iff (!rst_act_n)
    ref_gnt |-> (!beat_ack && row_strobe == 2'b00));
endmodule

bind line_wait_seq lws_checker #(.ADDR_W(ADDR_W)) u_lws_chk (
  .clk        (clk),
  .rst_act_n  (rst_act_n),
  .busy       (busy),
  .beat_ack   (beat_ack),
  .ref_gnt    (ref_gnt),
  .beat_addr  (beat_addr),
  .row_strobe (row_strobe),
  .col_strobe (col_strobe)
);

// File: tb/tb_line_wait_seq.sv
module tb_line_wait_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_line, ref_req;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [47:0] cfg_lat;
  logic        busy, beat_ack, bank_sel, ref_gnt;
  logic [31:0] beat_addr;
  logic [3:0]  beat_be;
  logic [1:0]  row_strobe, col_strobe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  line_wait_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_line(req_line),
    .cfg_lat(cfg_lat), .ref_req(ref_req), .busy(busy), .beat_ack(beat_ack),
    .beat_addr(beat_addr), .beat_be(beat_be), .bank_sel(bank_sel),
    .row_strobe(row_strobe), .col_strobe(col_strobe), .ref_gnt(ref_gnt)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] fld(input int r, input int s);
    return cfg_lat[(4*r+s)*4 +: 4];
  endfunction

  function automatic int clampv(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  task automatic set_rgn(input int r, input logic [3:0] rf, rn, wf, wn);
    cfg_lat[(4*r)*4 +: 16] = {wn, wf, rn, rf};
  endtask

  function automatic int rgn_of(input logic [31:0] a);
    if (a[31:28] == 4'h4) return 2;
    if (a[31:28] == 4'h5) return 1;
    return 0;
  endfunction

  // one transfer; expected timing derived from the field layout of R1
  task automatic run_xfer(input logic [31:0] a, input bit wr, input bit ln,
                          input logic [1:0] sz, input bit scramble);
    int r, f, n, beats, last, mism, nack, addr_bad, be_bad, bank_bad;
    logic [47:0] saved;
    logic [3:0]  exp_be;
    logic [1:0]  exp_row;
    logic [31:0] exp_a;
    string       tag;
    r = rgn_of(a);
    f = clampv(fld(r, wr ? 2 : 0));
    n = clampv(fld(r, wr ? 3 : 1));
    beats = ln ? 4 : 1;
    last  = f + (beats - 1) * n;
    tag   = ln ? (wr ? "R3" : "R2") : "R4";
    if (ln || sz[1])   exp_be = 4'b1111;
    else if (sz == 1)  exp_be = a[1] ? 4'b1100 : 4'b0011;
    else               exp_be = 4'b0001 << a[1:0];
    if (r == 2)        exp_row = 2'b00;
    else if (ln)       exp_row = 2'b11;
    else               exp_row = a[2] ? 2'b10 : 2'b01;
    saved = cfg_lat;
    mism = 0; nack = 0; addr_bad = 0; be_bad = 0; bank_bad = 0;
    @(negedge clk);
    req_addr = a; req_write = wr; req_line = ln; req_size = sz; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) cfg_lat = ~saved;
    for (int cyc = 1; cyc <= last + 1; cyc++) begin
      bit exp_ack;
      exp_ack = (cyc >= f) && ((cyc - f) % n == 0) && ((cyc - f) / n < beats);
      if (beat_ack !== exp_ack) mism++;
      if (cyc == 1) chk(busy === 1'b1, "R11 busy after take", {31'd0, busy}, 32'd1);
      if (cyc == 1) chk(row_strobe === exp_row, "R7 row strobe", {30'd0, row_strobe}, {30'd0, exp_row});
      if (beat_ack === 1'b1) begin
        exp_a = ln ? {a[31:4], 2'(a[3:2] + 2'(nack)), 2'b00} : a;
        if (beat_addr !== exp_a) addr_bad++;
        if (beat_be !== exp_be) be_bad++;
        if (bank_sel !== exp_a[2]) bank_bad++;
        if (col_strobe !== ((r == 2) ? 2'b00 : (exp_a[2] ? 2'b10 : 2'b01))) bank_bad++;
        nack++;
      end
      if (cyc == last + 1) chk(busy === 1'b0, "R11 busy after last beat", {31'd0, busy}, 32'd0);
      @(negedge clk);
    end
    chk(mism == 0 && nack == beats, scramble ? "R10 timing with cfg changed" : tag,
        32'(mism * 256 + nack), 32'(beats));
    chk(addr_bad == 0, "R6 beat address", 32'(addr_bad), 32'd0);
    chk(be_bad == 0, "R8 byte enables", 32'(be_bad), 32'd0);
    chk(bank_bad == 0, "R7 bank and column strobe", 32'(bank_bad), 32'd0);
    cfg_lat = saved;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [3];
    int t;
    bases[0] = 32'h0012_3400;
    bases[1] = 32'h5000_0040;
    bases[2] = 32'h4000_0100;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_line = 1'b0;
    req_size = 2'd2; req_addr = '0; ref_req = 1'b0; cfg_lat = '0;
    set_rgn(0, 4'd5, 4'd2, 4'd4, 4'd2);
    set_rgn(1, 4'd3, 4'd1, 4'd2, 4'd1);
    set_rgn(2, 4'd7, 4'd3, 4'd6, 4'd3);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && beat_ack === 1'b0 && ref_gnt === 1'b0, "R11 reset state",
        {29'd0, busy, beat_ack, ref_gnt}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && beat_ack === 1'b0 && ref_gnt === 1'b0, "R11 idle after reset",
        {29'd0, busy, beat_ack, ref_gnt}, 32'd0);

    // R1 R2 R3 R4 R6 R7: every region, direction, kind and line start
    for (int r = 0; r < 3; r++)
      for (int wr = 0; wr < 2; wr++)
        for (int lw = 0; lw < 4; lw++) begin
          run_xfer(bases[r] + 32'(lw * 4 + 3), wr[0], 1'b1, 2'd2, 1'b0);
          run_xfer(bases[r] + 32'(lw * 4), wr[0], 1'b0, 2'd2, 1'b0);
        end

    // R5: sweep first-beat field including 0, later-beat field 0..3
    for (int v = 0; v < 16; v++) begin
      set_rgn(0, 4'(v), 4'(v % 4), 4'd4, 4'd2);
      run_xfer(32'h0000_1000, 1'b0, 1'b1, 2'd2, 1'b0);
    end
    set_rgn(0, 4'd6, 4'd3, 4'd0, 4'd0);
    run_xfer(32'h0000_2008, 1'b1, 1'b1, 2'd2, 1'b0);
    set_rgn(0, 4'd5, 4'd2, 4'd4, 4'd2);

    // R8: single transfer byte enables
    for (int sz = 0; sz < 4; sz++)
      for (int lo = 0; lo < 4; lo++)
        run_xfer(32'h0000_3000 + 32'(lo), 1'b0, 1'b0, 2'(sz), 1'b0);

    // R10: configuration changed right after the request is taken
    run_xfer(32'h0000_4004, 1'b0, 1'b1, 2'd2, 1'b1);
    run_xfer(32'h4000_0008, 1'b1, 1'b0, 2'd2, 1'b1);

    // R9: refresh and request in the same idle cycle, refresh wins
    @(negedge clk);
    ref_req = 1'b1; req_valid = 1'b1; req_addr = 32'h0000_5000;
    req_line = 1'b0; req_write = 1'b0; req_size = 2'd2;
    @(negedge clk);
    chk(ref_gnt === 1'b1, "R9 refresh wins tie", {31'd0, ref_gnt}, 32'd1);
    t = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ref_gnt !== 1'b1 || beat_ack !== 1'b0) t++;
    end
    chk(t == 0, "R9 grant held, request not taken", 32'(t), 32'd0);
    ref_req = 1'b0;
    @(negedge clk);
    chk(ref_gnt === 1'b0 && busy === 1'b0, "R9 release to idle", {30'd0, ref_gnt, busy}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1 && ref_gnt === 1'b0, "R9 request taken after refresh", {30'd0, busy, ref_gnt}, 32'd2);
    while (busy === 1'b1) @(negedge clk);

    // R9: refresh asked in mid-burst waits for the line to finish (5-2-2-2, last at 11)
    @(negedge clk);
    req_addr = 32'h0000_6000; req_line = 1'b1; req_write = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; ref_req = 1'b1;
    t = 0;
    begin
      int first_gnt, acks;
      first_gnt = 0; acks = 0;
      for (int cyc = 1; cyc <= 16; cyc++) begin
        if (beat_ack === 1'b1) acks++;
        if (ref_gnt === 1'b1 && first_gnt == 0) first_gnt = cyc;
        @(negedge clk);
      end
      chk(first_gnt == 13, "R9 grant after burst", 32'(first_gnt), 32'd13);
      chk(acks == 4, "R9 burst completes under refresh request", 32'(acks), 32'd4);
    end
    ref_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R11 idle at end", {31'd0, busy}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule